// File: doc/BRIEF.md
# CAN receive identifier matching engine

This block picks the destination of a frame arriving on a CAN bus. When the frame's CRC field begins, the engine copies the decoded frame into a hidden holding buffer. It then walks the candidate destinations one per clock. The receive FIFO's identifier table comes first, if the FIFO is enabled and has room. The regular receive mailboxes follow, in ascending index order. Each candidate is tested against the received identifier under its own mask. The first hit becomes the winner, and the walk stops there.

The engine does not move the frame when the scan ends. It holds the winner until the sixth end-of-frame bit strobe, and only then issues a single write command carrying the buffered contents. A protocol error seen at any point from the CRC start up to that strobe cancels the write. A frame that this node sent itself is dropped when self-reception is disabled, and it then produces no write command.

States: `ST_IDLE` (no frame pending), `ST_FIFO` (walking FIFO table entries), `ST_MB` (walking mailboxes), `ST_HOLD` (scan over, waiting for the end-of-frame strobe). Transitions:
- The CRC-start strobe goes from any state to `ST_FIFO` when the FIFO is enabled and not full.
- The CRC-start strobe goes to `ST_MB` when the FIFO is disabled or full.
- The CRC-start strobe goes straight to `ST_HOLD`, with no winner, for a self-sent frame while self-reception is disabled.
- A FIFO hit goes from `ST_FIFO` to `ST_HOLD`. Running past the last table entry goes to `ST_MB`.
- A mailbox hit, or running past the last mailbox, goes from `ST_MB` to `ST_HOLD`.
- The end-of-frame strobe returns any non-idle state to `ST_IDLE`.

Top module: `can_rx_match`

## Requirements
- R1: After reset, `mv_valid_o` is 0.
- R2: With the FIFO enabled and not full, FIFO table entries are tested first, lowest entry first. A hit writes to the FIFO: `mv_to_fifo_o`=1 and `mv_idx_o` is the entry index. This holds even when a mailbox also matches.
- R3: When no FIFO entry hits, the winner is the lowest-index mailbox that is free and matches. The result is `mv_to_fifo_o`=0 with `mv_idx_o` set to that mailbox.
- R4: When the FIFO is full or disabled, the FIFO table is skipped, even if an entry matches, and only mailboxes compete.
- R5: A match key is 30 bits: bit 29 is the extended-format flag and bits 28:0 are the identifier. A mask bit of 1 requires the key bits to be equal. A mask bit of 0 makes that bit don't-care.
- R6: The write command is a one-cycle pulse on `mv_valid_o`. It appears in the cycle after the end-of-frame strobe is sampled, and never before that strobe.
- R7: A protocol error indicated between the CRC-start strobe and the end-of-frame strobe, including at the strobe itself, cancels the write.
- R8: The write carries the received key, DLC, RTR flag and data from the holding buffer. The received key is written even when the winner's stored key differs in masked bits.
- R9: A self-sent frame produces no write while self-reception is disabled. It is stored normally while self-reception is enabled.
- R10: A frame that matches no candidate produces no write.
- R11: A mailbox whose free flag is 0 is skipped, even when its key matches.
- R12: The scan tests one candidate per clock. It ends within FIFO_N+NUM_MB cycles of the CRC-start strobe, so an end-of-frame strobe sampled FIFO_N+NUM_MB+1 cycles after it still writes into the last mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_start_i | input | 1 | Strobe at the start of the CRC field; the frame fields are valid then |
| eof6_i | input | 1 | Strobe at the sixth end-of-frame bit |
| proto_err_i | input | 1 | Protocol error seen on the current frame |
| self_tx_i | input | 1 | Current frame was sent by this node |
| self_rx_dis_i | input | 1 | Self-reception disabled |
| rx_key_i | input | KEY_W | Received key {ext flag, identifier} |
| rx_rtr_i | input | 1 | Received remote-request flag |
| rx_dlc_i | input | 4 | Received data length code |
| rx_data_i | input | DATA_W | Received payload |
| fifo_en_i | input | 1 | Receive FIFO enabled |
| fifo_full_i | input | 1 | Receive FIFO has no room |
| fifo_key_i | input | FIFO_N*KEY_W | FIFO table keys, entry i at bits [i*KEY_W +: KEY_W] |
| fifo_mask_i | input | FIFO_N*KEY_W | FIFO table masks, same layout |
| mb_key_i | input | NUM_MB*KEY_W | Mailbox keys, mailbox i at bits [i*KEY_W +: KEY_W] |
| mb_mask_i | input | NUM_MB*KEY_W | Mailbox masks, same layout |
| mb_free_i | input | NUM_MB | Mailbox i is free to receive |
| mv_valid_o | output | 1 | Write command pulse |
| mv_to_fifo_o | output | 1 | Write target is the FIFO (1) or a mailbox (0) |
| mv_idx_o | output | IDX_W | FIFO entry or mailbox index |
| mv_key_o | output | KEY_W | Key to write |
| mv_rtr_o | output | 1 | RTR flag to write |
| mv_dlc_o | output | 4 | DLC to write |
| mv_data_o | output | DATA_W | Payload to write |

## Verification
The bench sets up frames that match several candidates at once. An engine with the priority wrong would pick a mailbox over the FIFO, a higher mailbox over a lower one, or a busy mailbox. It would also consult the FIFO table while the FIFO is full.

Another frame hits a FIFO entry only through masked bits. A design that copied the stored key, instead of the received one, shows the wrong `mv_key_o`.

Further tests inject a protocol error in the gap before end-of-frame, and send a self-sent frame with self-reception off. An engine that commits early or ignores these flags emits a write that should not exist.

The last test places the only winner in the final mailbox and strobes end-of-frame at the earliest legal cycle. A scan that is slower than one candidate per clock, or that drops the final index, writes nothing.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIFO,
        ST_MB,
        ST_HOLD
    } rxm_state_e;
endpackage

// File: rtl/rxm_cmp.sv
module rxm_cmp #(
    parameter int KEY_W = 30
) (
    input  logic [KEY_W-1:0] rx_key_i,
    input  logic [KEY_W-1:0] ent_key_i,
    input  logic [KEY_W-1:0] ent_mask_i,
    output logic             hit_o
);
    // Only bits with a mask of 1 take part in the comparison.
    assign hit_o = ((rx_key_i ^ ent_key_i) & ent_mask_i) == '0;
endmodule

// File: rtl/rxm_smb.sv
module rxm_smb #(
    parameter int KEY_W  = 30,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              rtr_i,
    input  logic [3:0]        dlc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              self_i,
    output logic [KEY_W-1:0]  key_o,
    output logic              rtr_o,
    output logic [3:0]        dlc_o,
    output logic [DATA_W-1:0] data_o,
    output logic              self_o
);
    // Hidden holding buffer: captured once per frame, stable until the next one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_o  <= '0;
            rtr_o  <= 1'b0;
            dlc_o  <= '0;
            data_o <= '0;
            self_o <= 1'b0;
        end else if (load_i) begin
            key_o  <= key_i;
            rtr_o  <= rtr_i;
            dlc_o  <= dlc_i;
            data_o <= data_i;
            self_o <= self_i;
        end
    end
endmodule

// File: rtl/rxm_scan.sv
module rxm_scan
    import rxm_pkg::*;
#(
    parameter int FIFO_N = 8,
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4,
    localparam int FIFO_W = $clog2(FIFO_N),
    localparam int MB_W   = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              drop_i,
    input  logic              fifo_go_i,
    input  logic              fifo_hit_i,
    input  logic              mb_hit_i,
    input  logic              err_i,
    input  logic              eof6_i,
    output logic [FIFO_W-1:0] fifo_idx_o,
    output logic [MB_W-1:0]   mb_idx_o,
    output logic              mv_valid_o,
    output logic              mv_to_fifo_o,
    output logic [IDX_W-1:0]  mv_idx_o
);
    localparam int SCAN_MAX = FIFO_N + NUM_MB;
    localparam int CYC_W    = $clog2(SCAN_MAX + 2) + 1;

    rxm_state_e        state_q, state_d;
    logic [FIFO_W-1:0] fifo_idx_q, fifo_idx_d;
    logic [MB_W-1:0]   mb_idx_q, mb_idx_d;
    logic              has_win_q, has_win_d;
    logic              win_fifo_q, win_fifo_d;
    logic [IDX_W-1:0]  win_idx_q, win_idx_d;
    logic              err_q, err_d;
    logic [CYC_W-1:0]  scan_cyc_q;
    logic              move_now;

    assign fifo_idx_o = fifo_idx_q;
    assign mb_idx_o   = mb_idx_q;

    // Next state and scan bookkeeping
    always_comb begin
        state_d    = state_q;
        fifo_idx_d = fifo_idx_q;
        mb_idx_d   = mb_idx_q;
        has_win_d  = has_win_q;
        win_fifo_d = win_fifo_q;
        win_idx_d  = win_idx_q;
        err_d      = err_q | err_i;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIFO: begin
                if (fifo_hit_i) begin
                    has_win_d  = 1'b1;
                    win_fifo_d = 1'b1;
                    win_idx_d  = IDX_W'(fifo_idx_q);
                    state_d    = ST_HOLD;
                end else if (fifo_idx_q == FIFO_W'(FIFO_N - 1)) begin
                    mb_idx_d = '0;
                    state_d  = ST_MB;
                end else begin
                    fifo_idx_d = fifo_idx_q + 1'b1;
                end
            end
            ST_MB: begin
                if (mb_hit_i) begin
                    has_win_d  = 1'b1;
                    win_fifo_d = 1'b0;
                    win_idx_d  = IDX_W'(mb_idx_q);
                    state_d    = ST_HOLD;
                end else if (mb_idx_q == MB_W'(NUM_MB - 1)) begin
                    state_d = ST_HOLD;
                end else begin
                    mb_idx_d = mb_idx_q + 1'b1;
                end
            end
            ST_HOLD: ;
            default: state_d = ST_IDLE;
        endcase
        if (eof6_i && state_q != ST_IDLE) begin
            state_d = ST_IDLE;
        end
        if (start_i) begin
            fifo_idx_d = '0;
            mb_idx_d   = '0;
            has_win_d  = 1'b0;
            win_fifo_d = 1'b0;
            win_idx_d  = '0;
            err_d      = 1'b0;
            if (drop_i) begin
                state_d = ST_HOLD;
            end else if (fifo_go_i) begin
                state_d = ST_FIFO;
            end else begin
                state_d = ST_MB;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fifo_idx_q <= '0;
            mb_idx_q   <= '0;
            has_win_q  <= 1'b0;
            win_fifo_q <= 1'b0;
            win_idx_q  <= '0;
            err_q      <= 1'b0;
            scan_cyc_q <= '0;
        end else begin
            state_q    <= state_d;
            fifo_idx_q <= fifo_idx_d;
            mb_idx_q   <= mb_idx_d;
            has_win_q  <= has_win_d;
            win_fifo_q <= win_fifo_d;
            win_idx_q  <= win_idx_d;
            err_q      <= err_d;
            if (start_i) begin
                scan_cyc_q <= '0;
            end else if (state_q == ST_FIFO || state_q == ST_MB) begin
                scan_cyc_q <= scan_cyc_q + 1'b1;
            end
        end
    end

    assign move_now = (state_q == ST_HOLD) && eof6_i && has_win_q && !err_q && !err_i;

    // Outputs: the write command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_valid_o   <= 1'b0;
            mv_to_fifo_o <= 1'b0;
            mv_idx_o     <= '0;
        end else begin
            mv_valid_o <= move_now;
            if (move_now) begin
                mv_to_fifo_o <= win_fifo_q;
                mv_idx_o     <= win_idx_q;
            end
        end
    end

    // R12
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIFO || state_q == ST_MB) |-> scan_cyc_q < CYC_W'(SCAN_MAX));

    // R4
    fifo_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !fifo_go_i) |=> state_q != ST_FIFO);
endmodule

// File: rtl/can_rx_match.sv
module can_rx_match #(
    parameter int FIFO_N = 8,
    parameter int NUM_MB = 16,
    parameter int KEY_W  = 30,
    parameter int DATA_W = 64,
    localparam int FIFO_W = $clog2(FIFO_N),
    localparam int MB_W   = $clog2(NUM_MB),
    localparam int IDX_W  = (MB_W > FIFO_W) ? MB_W : FIFO_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    crc_start_i,
    input  logic                    eof6_i,
    input  logic                    proto_err_i,
    input  logic                    self_tx_i,
    input  logic                    self_rx_dis_i,
    input  logic [KEY_W-1:0]        rx_key_i,
    input  logic                    rx_rtr_i,
    input  logic [3:0]              rx_dlc_i,
    input  logic [DATA_W-1:0]       rx_data_i,
    input  logic                    fifo_en_i,
    input  logic                    fifo_full_i,
    input  logic [FIFO_N*KEY_W-1:0] fifo_key_i,
    input  logic [FIFO_N*KEY_W-1:0] fifo_mask_i,
    input  logic [NUM_MB*KEY_W-1:0] mb_key_i,
    input  logic [NUM_MB*KEY_W-1:0] mb_mask_i,
    input  logic [NUM_MB-1:0]       mb_free_i,
    output logic                    mv_valid_o,
    output logic                    mv_to_fifo_o,
    output logic [IDX_W-1:0]        mv_idx_o,
    output logic [KEY_W-1:0]        mv_key_o,
    output logic                    mv_rtr_o,
    output logic [3:0]              mv_dlc_o,
    output logic [DATA_W-1:0]       mv_data_o
);
    logic [KEY_W-1:0]  smb_key;
    logic              smb_self;
    logic [FIFO_W-1:0] fifo_idx;
    logic [MB_W-1:0]   mb_idx;
    logic              fifo_cmp_hit, mb_cmp_hit;

    rxm_smb #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_smb (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (crc_start_i),
        .key_i  (rx_key_i),
        .rtr_i  (rx_rtr_i),
        .dlc_i  (rx_dlc_i),
        .data_i (rx_data_i),
        .self_i (self_tx_i),
        .key_o  (smb_key),
        .rtr_o  (mv_rtr_o),
        .dlc_o  (mv_dlc_o),
        .data_o (mv_data_o),
        .self_o (smb_self)
    );

    assign mv_key_o = smb_key;

    rxm_cmp #(.KEY_W(KEY_W)) u_cmp_fifo (
        .rx_key_i   (smb_key),
        .ent_key_i  (fifo_key_i[fifo_idx*KEY_W +: KEY_W]),
        .ent_mask_i (fifo_mask_i[fifo_idx*KEY_W +: KEY_W]),
        .hit_o      (fifo_cmp_hit)
    );

    rxm_cmp #(.KEY_W(KEY_W)) u_cmp_mb (
        .rx_key_i   (smb_key),
        .ent_key_i  (mb_key_i[mb_idx*KEY_W +: KEY_W]),
        .ent_mask_i (mb_mask_i[mb_idx*KEY_W +: KEY_W]),
        .hit_o      (mb_cmp_hit)
    );

    rxm_scan #(.FIFO_N(FIFO_N), .NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (crc_start_i),
        .drop_i       (self_tx_i && self_rx_dis_i),
        .fifo_go_i    (fifo_en_i && !fifo_full_i),
        .fifo_hit_i   (fifo_cmp_hit),
        .mb_hit_i     (mb_cmp_hit && mb_free_i[mb_idx]),
        .err_i        (proto_err_i),
        .eof6_i       (eof6_i),
        .fifo_idx_o   (fifo_idx),
        .mb_idx_o     (mb_idx),
        .mv_valid_o   (mv_valid_o),
        .mv_to_fifo_o (mv_to_fifo_o),
        .mv_idx_o     (mv_idx_o)
    );

    // R6
    move_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid_o |-> $past(eof6_i));

    // R6
    move_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid_o |=> !mv_valid_o);

    // R7
    move_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid_o |-> !$past(proto_err_i));

    // R9
    self_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid_o |-> !(smb_self && self_rx_dis_i));

    // R11
    mb_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid_o && !mv_to_fifo_o) |-> mb_free_i[mv_idx_o[MB_W-1:0]]);

    // R2
    fifo_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid_o && mv_to_fifo_o) |-> fifo_en_i);
endmodule

// File: tb/can_rx_match_bench.sv
module can_rx_match_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FIFO_N = 8;
    localparam int NUM_MB = 16;
    localparam int KEY_W  = 30;
    localparam int DATA_W = 64;
    localparam int IDX_W  = 4;
    localparam logic [KEY_W-1:0] K1 = 30'h2ABC1234;
    localparam logic [KEY_W-1:0] K2 = 30'h00001555;
    localparam logic [DATA_W-1:0] DAT = 64'hDEADBEEF01234567;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic crc_start = 1'b0, eof6 = 1'b0, perr = 1'b0, self_tx = 1'b0, self_dis = 1'b0;
    logic [KEY_W-1:0] rx_key = '0;
    logic rx_rtr = 1'b0;
    logic [3:0] rx_dlc = '0;
    logic [DATA_W-1:0] rx_data = '0;
    logic fifo_en = 1'b0, fifo_full = 1'b0;
    logic [FIFO_N*KEY_W-1:0] fifo_key, fifo_mask;
    logic [NUM_MB*KEY_W-1:0] mb_key, mb_mask;
    logic [NUM_MB-1:0] mb_free;
    logic mv_valid, mv_to_fifo, mv_rtr;
    logic [IDX_W-1:0] mv_idx;
    logic [KEY_W-1:0] mv_key;
    logic [3:0] mv_dlc;
    logic [DATA_W-1:0] mv_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_rx_match #(.FIFO_N(FIFO_N), .NUM_MB(NUM_MB), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_can_rx_match (
        .clk(clk), .rst_n(rst_n), .crc_start_i(crc_start), .eof6_i(eof6),
        .proto_err_i(perr), .self_tx_i(self_tx), .self_rx_dis_i(self_dis),
        .rx_key_i(rx_key), .rx_rtr_i(rx_rtr), .rx_dlc_i(rx_dlc), .rx_data_i(rx_data),
        .fifo_en_i(fifo_en), .fifo_full_i(fifo_full),
        .fifo_key_i(fifo_key), .fifo_mask_i(fifo_mask),
        .mb_key_i(mb_key), .mb_mask_i(mb_mask), .mb_free_i(mb_free),
        .mv_valid_o(mv_valid), .mv_to_fifo_o(mv_to_fifo), .mv_idx_o(mv_idx),
        .mv_key_o(mv_key), .mv_rtr_o(mv_rtr), .mv_dlc_o(mv_dlc), .mv_data_o(mv_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every entry holds an all-ones key under a full mask: no test key matches it.
    task automatic clear_tables();
        fifo_key  = '1;
        fifo_mask = '1;
        mb_key    = '1;
        mb_mask   = '1;
        mb_free   = '0;
        fifo_en   = 1'b1;
        fifo_full = 1'b0;
        self_dis  = 1'b0;
    endtask

    task automatic set_fifo(input int i, input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] m);
        fifo_key[i*KEY_W +: KEY_W]  = k;
        fifo_mask[i*KEY_W +: KEY_W] = m;
    endtask

    task automatic set_mb(input int i, input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] m,
                          input logic fr);
        mb_key[i*KEY_W +: KEY_W]  = k;
        mb_mask[i*KEY_W +: KEY_W] = m;
        mb_free[i]                = fr;
    endtask

    // Runs one frame; gap = cycles between the CRC-start strobe and the end-of-frame strobe.
    task automatic frame(input logic [KEY_W-1:0] k, input logic self_f, input logic inj_err,
                         input int gap, output logic v, output logic tf,
                         output logic [IDX_W-1:0] idx, output logic early, output logic after);
        early = 1'b0;
        @(negedge clk);
        rx_key = k; self_tx = self_f; rx_rtr = 1'b1; rx_dlc = 4'd8; rx_data = DAT;
        crc_start = 1'b1;
        @(negedge clk);
        crc_start = 1'b0;
        rx_key = '0; rx_data = '0; rx_dlc = '0; rx_rtr = 1'b0;
        for (int c = 0; c < gap; c++) begin
            perr = inj_err && (c == gap / 2);
            @(negedge clk);
            if (mv_valid) early = 1'b1;
        end
        perr = 1'b0;
        eof6 = 1'b1;
        @(negedge clk);
        eof6 = 1'b0;
        v = mv_valid; tf = mv_to_fifo; idx = mv_idx;
        @(negedge clk);
        after = mv_valid;
        self_tx = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset mv_valid", 64'(mv_valid), 64'd0);
    endtask

    task automatic t_fifo_first();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_fifo(2, K1 ^ 30'h0F0, ~30'h0F0);
        set_fifo(5, K1, '1);
        set_mb(0, K1, '1, 1'b1);
        frame(K1, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R2 fifo move valid", 64'(v), 64'd1);
        chk("R2 target fifo", 64'(tf), 64'd1);
        chk("R2 lowest fifo entry", 64'(ix), 64'd2);
        chk("R8 received key written", 64'(mv_key), 64'(K1));
        chk("R8 dlc", 64'(mv_dlc), 64'd8);
        chk("R8 rtr", 64'(mv_rtr), 64'd1);
        chk("R8 data", mv_data, DAT);
        chk("R6 no early move", 64'(e), 64'd0);
        chk("R6 single-cycle pulse", 64'(a), 64'd0);
    endtask

    task automatic t_mb_lowest_free();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_mb(3, K1, '1, 1'b0);
        set_mb(5, K1, '1, 1'b1);
        set_mb(9, K1, '1, 1'b1);
        frame(K1, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R3 mb move valid", 64'(v), 64'd1);
        chk("R3 target mailbox", 64'(tf), 64'd0);
        chk("R11 busy mb3 skipped, R3 lowest free", 64'(ix), 64'd5);
    endtask

    task automatic t_fifo_skipped(input logic full, input logic en);
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        fifo_full = full; fifo_en = en;
        set_fifo(0, K1, '1);
        set_mb(7, K1, '1, 1'b1);
        frame(K1, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R4 move valid", 64'(v), 64'd1);
        chk("R4 fifo skipped", 64'(tf), 64'd0);
        chk("R4 mailbox index", 64'(ix), 64'd7);
    endtask

    task automatic t_mask();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_mb(1, K2 ^ 30'h1, '1, 1'b1);
        set_mb(2, K2 | 30'h20000000, ~30'h20000000, 1'b1);
        frame(K2, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R5 don't-care ext bit matches", 64'(v), 64'd1);
        chk("R5 required bit rejects mb1", 64'(ix), 64'd2);
        chk("R8 key from frame", 64'(mv_key), 64'(K2));
        clear_tables();
        set_mb(1, K2 ^ 30'h1, '1, 1'b1);
        frame(K2, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R5 required bit differs, no move", 64'(v), 64'd0);
    endtask

    task automatic t_error();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_mb(0, K1, '1, 1'b1);
        frame(K1, 1'b0, 1'b1, 30, v, tf, ix, e, a);
        chk("R7 error cancels move", 64'(v), 64'd0);
        frame(K1, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R7 next clean frame moves", 64'(v), 64'd1);
    endtask

    task automatic t_self();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_mb(4, K1, '1, 1'b1);
        self_dis = 1'b1;
        frame(K1, 1'b1, 1'b0, 30, v, tf, ix, e, a);
        chk("R9 self frame dropped", 64'(v), 64'd0);
        chk("R9 no early move when dropped", 64'(e), 64'd0);
        self_dis = 1'b0;
        frame(K1, 1'b1, 1'b0, 30, v, tf, ix, e, a);
        chk("R9 self frame stored when enabled", 64'(v), 64'd1);
        chk("R9 index", 64'(ix), 64'd4);
    endtask

    task automatic t_nomatch();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_mb(0, K2, '1, 1'b1);
        frame(K1, 1'b0, 1'b0, 30, v, tf, ix, e, a);
        chk("R10 no match, no move", 64'(v), 64'd0);
    endtask

    task automatic t_last_mb();
        logic v, tf, e, a; logic [IDX_W-1:0] ix;
        clear_tables();
        set_mb(NUM_MB - 1, K1, '1, 1'b1);
        frame(K1, 1'b0, 1'b0, FIFO_N + NUM_MB, v, tf, ix, e, a);
        chk("R12 last mailbox reached in time", 64'(v), 64'd1);
        chk("R12 last mailbox index", 64'(ix), 64'(NUM_MB - 1));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_tables();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo_first();
        t_mb_lowest_free();
        t_fifo_skipped(1'b1, 1'b1);
        t_fifo_skipped(1'b0, 1'b0);
        t_mask();
        t_error();
        t_self();
        t_nomatch();
        t_last_mb();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule